// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block decides which analog input channel the converter handles next and paces each conversion. Three request flows feed it: a regular scan, a hardware-injected command and a software-injected command. Each flow supplies a channel mask of up to 16 bits together with a start pulse. The block keeps the channels that are still outstanding for every flow. At every channel boundary it grants one flow, and then it runs that flow's lowest outstanding channel through a sample phase and a convert phase.

Both injected flows outrank the regular scan. A configuration input sets which of the two injected flows wins when both are waiting. An injected request never aborts a conversion already under way; it is taken at the next channel boundary. The regular scan then picks up again at its lowest channel not yet converted. The sample phase has a selectable length, and the analog converter is represented by a conversion-complete input that the surrounding logic returns. Each finished channel gives a one-cycle result tag carrying the channel and the flow. A per-flow end-of-chain pulse marks the last channel of that flow.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: When reset is released, busy, sample_en, conv_start, res_valid and all three eoc outputs are 0, and ch_sel is 0.
- R2: A start pulse loads its flow's mask only if that mask is non-zero and the flow has no outstanding channels. Any other start pulse leaves the outstanding set unchanged.
- R3: Within one flow, every selected channel is converted exactly once, in ascending index order. res_ch gives the channel and res_flow gives the flow: 0 regular, 1 hardware-injected, 2 software-injected.
- R4: At each channel boundary, an outstanding injected flow is granted before the regular flow. After the injected work, the regular scan continues from its lowest channel not yet converted.
- R5: When both injected flows are outstanding, sw_over_hw = 1 grants the software-injected flow first and sw_over_hw = 0 grants the hardware-injected flow first.
- R6: sample_en stays high for exactly 2, 8, 64 or 128 cycles for smp_sel codes 0, 1, 2 and 3. The code is taken when the sample phase begins.
- R7: conv_start is a one-cycle pulse in the cycle just after sample_en falls, and it is never high together with sample_en. ch_sel holds the granted channel from the start of the sample phase until its result.
- R8: res_valid pulses for one cycle, in the cycle after conv_done is seen during the convert phase. conv_done at any other time has no effect.
- R9: eoc_reg, eoc_hw and eoc_sw each pulse together with res_valid for the last outstanding channel of their own flow, and never at any other time.
- R10: busy is high while any flow has outstanding channels or a conversion is in progress, and it drops once all work has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_start | input | 1 | Start pulse for the regular scan flow |
| reg_mask | input | NUM_CH | Channel mask for the regular scan |
| hw_start | input | 1 | Start pulse for the hardware-injected flow |
| hw_mask | input | NUM_CH | Channel mask for the hardware-injected flow |
| sw_start | input | 1 | Start pulse for the software-injected flow |
| sw_mask | input | NUM_CH | Channel mask for the software-injected flow |
| sw_over_hw | input | 1 | 1: software-injected outranks hardware-injected |
| smp_sel | input | 2 | Sample length code: 2, 8, 64 or 128 cycles |
| conv_done | input | 1 | Conversion-complete from the converter |
| ch_sel | output | CW | Channel routed to the converter |
| sample_en | output | 1 | High during the sample phase |
| conv_start | output | 1 | One-cycle convert start pulse |
| res_valid | output | 1 | One-cycle result tag strobe |
| res_ch | output | CW | Channel of the finished conversion |
| res_flow | output | 2 | Flow of the finished conversion |
| eoc_reg | output | 1 | Regular flow end of chain |
| eoc_hw | output | 1 | Hardware-injected flow end of chain |
| eoc_sw | output | 1 | Software-injected flow end of chain |
| busy | output | 1 | Work outstanding or in progress |

## Verification
The bench builds the block with its default NUM_CH of 16. This lets random masks reach both the top channel and the bottom one, so the lowest-set-bit search is tested over the whole index range. The converter model returns conv_done three cycles after each conv_start. Most batches use the 2- and 8-cycle sample codes to keep the many random channel orders affordable. Single-channel directed batches cover the 64- and 128-cycle codes, and further directed batches cover injection in the middle of a scan, stray completion pulses and start pulses that must be ignored.

// File: rtl/adc_seq_pkg.sv
// Package: shared state and flow encodings plus the sample-length decode.
// Assumes the sample length codes 0..3 map to 2, 8, 64 and 128 cycles.
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_NEXT    = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        FL_REG = 2'd0,
        FL_HW  = 2'd1,
        FL_SW  = 2'd2
    } flow_t;

    localparam int NUM_FLOWS = 3;
    localparam int SMP_MAX   = 128;
    localparam int SMP_CNT_W = $clog2(SMP_MAX);

    // Counter reload value: phase length minus one.
    function automatic logic [SMP_CNT_W-1:0] smp_reload(input logic [1:0] code);
        logic [SMP_CNT_W-1:0] v;
        case (code)
            2'd0:    v = SMP_CNT_W'(1);
            2'd1:    v = SMP_CNT_W'(7);
            2'd2:    v = SMP_CNT_W'(63);
            default: v = SMP_CNT_W'(SMP_MAX - 1);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/adc_flow_slot.sv
// Module: adc_flow_slot
// Holds the outstanding channel set of one request flow. It loads a new mask
// on start only when nothing is outstanding and the mask is non-zero, clears
// one channel when that channel's conversion completes, and reports the
// lowest outstanding channel and whether a clear empties the set.
// Assumes clr never coincides with an empty set.
module adc_flow_slot #(
    parameter int NUM_CH = 16,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CH-1:0] mask,
    input  logic              clr,
    input  logic [CW-1:0]     clr_idx,
    output logic              any,
    output logic [CW-1:0]     first_idx,
    output logic              is_last
);

    logic [NUM_CH-1:0] pend;
    logic [NUM_CH-1:0] clr_bit;

    assign clr_bit = NUM_CH'(1) << clr_idx;

    // Outstanding set: load on accepted start, drop a channel on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else if (start && (pend == '0) && (mask != '0)) begin
            pend <= mask;
        end else if (clr) begin
            pend <= pend & ~clr_bit;
        end
    end

    // Lowest set bit of the outstanding set.
    always_comb begin
        first_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pend[i]) first_idx = CW'(i);
        end
    end

    assign any     = (pend != '0);
    assign is_last = ((pend & ~clr_bit) == '0);

endmodule

// File: rtl/adc_flow_arbiter.sv
// Module: adc_flow_arbiter
// Combinational grant among the three flows. Both injected flows outrank the
// regular flow, and sw_over_hw orders the two injected flows.
// Assumes req bit order {sw, hw, reg}.
module adc_flow_arbiter
    import adc_seq_pkg::*;
(
    input  logic [NUM_FLOWS-1:0] req,
    input  logic                 sw_over_hw,
    output logic                 gnt_valid,
    output flow_t                gnt_flow
);

    // Fixed-plus-programmable priority pick.
    always_comb begin
        gnt_valid = |req;
        gnt_flow  = FL_REG;
        if (req[FL_SW] && (sw_over_hw || !req[FL_HW])) begin
            gnt_flow = FL_SW;
        end else if (req[FL_HW]) begin
            gnt_flow = FL_HW;
        end
    end

endmodule

// File: rtl/adc_sample_timer.sv
// Module: adc_sample_timer
// Down-counter for the sample phase. It is loaded with the phase length
// minus one, counts while run is high, and reports expiry at zero.
// Assumes load and run are not high together.
module adc_sample_timer
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    input  logic       run,
    output logic       expired
);

    logic [SMP_CNT_W-1:0] cnt;

    // Reload on grant, then count down to zero while sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= smp_reload(code);
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/adc_cmd_sequencer.sv
// Module: adc_cmd_sequencer (top)
// Arbitrates the regular, hardware-injected and software-injected flows at
// channel boundaries, and runs each granted channel through SAMPLE and
// CONVERT. It tags each result with its channel and flow, and pulses a
// per-flow end of chain on the last channel.
// Assumes conv_done comes back from the converter after conv_start.
module adc_cmd_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CW    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_start,
    input  logic [NUM_CH-1:0] reg_mask,
    input  logic              hw_start,
    input  logic [NUM_CH-1:0] hw_mask,
    input  logic              sw_start,
    input  logic [NUM_CH-1:0] sw_mask,
    input  logic              sw_over_hw,
    input  logic [1:0]        smp_sel,
    input  logic              conv_done,
    output logic [CW-1:0]     ch_sel,
    output logic              sample_en,
    output logic              conv_start,
    output logic              res_valid,
    output logic [CW-1:0]     res_ch,
    output logic [1:0]        res_flow,
    output logic              eoc_reg,
    output logic              eoc_hw,
    output logic              eoc_sw,
    output logic              busy
);

    seq_state_t           state;
    flow_t                act_flow;
    logic [CW-1:0]        act_ch;
    logic [NUM_FLOWS-1:0] start_v;
    logic [NUM_CH-1:0]    mask_v [NUM_FLOWS];
    logic [NUM_FLOWS-1:0] pend_any;
    logic [CW-1:0]        first_v [NUM_FLOWS];
    logic [NUM_FLOWS-1:0] last_v;
    logic [NUM_FLOWS-1:0] clr_v;
    logic [NUM_FLOWS-1:0] eoc_q;
    logic                 gnt_valid;
    flow_t                gnt_flow;
    logic                 take_grant;
    logic                 smp_expired;
    logic                 done_seen;
    logic                 conv_start_q;

    assign start_v   = {sw_start, hw_start, reg_start};
    assign mask_v[0] = reg_mask;
    assign mask_v[1] = hw_mask;
    assign mask_v[2] = sw_mask;

    assign done_seen  = (state == ST_CONVERT) && conv_done;
    assign take_grant = ((state == ST_IDLE) || (state == ST_NEXT)) && gnt_valid;

    // One outstanding-set slot per flow.
    for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_slot
        assign clr_v[f] = done_seen && (act_flow == flow_t'(f));

        adc_flow_slot #(.NUM_CH(NUM_CH)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (start_v[f]),
            .mask      (mask_v[f]),
            .clr       (clr_v[f]),
            .clr_idx   (act_ch),
            .any       (pend_any[f]),
            .first_idx (first_v[f]),
            .is_last   (last_v[f])
        );
    end

    adc_flow_arbiter u_arb (
        .req        (pend_any),
        .sw_over_hw (sw_over_hw),
        .gnt_valid  (gnt_valid),
        .gnt_flow   (gnt_flow)
    );

    adc_sample_timer u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take_grant),
        .code    (smp_sel),
        .run     (state == ST_SAMPLE),
        .expired (smp_expired)
    );

    // Sequencing state machine: grant, sample, convert, boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE, ST_NEXT: state <= gnt_valid ? ST_SAMPLE : ST_IDLE;
                ST_SAMPLE:        if (smp_expired) state <= ST_CONVERT;
                ST_CONVERT:       if (conv_done) state <= ST_NEXT;
                default:          state <= ST_IDLE;
            endcase
        end
    end

    // Capture the granted flow and channel at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_flow <= FL_REG;
            act_ch   <= '0;
        end else if (take_grant) begin
            act_flow <= gnt_flow;
            act_ch   <= first_v[gnt_flow];
        end
    end

    // One-cycle convert start on leaving the sample phase.
    always_ff @(posedge clk) begin
        if (!rst_n) conv_start_q <= 1'b0;
        else        conv_start_q <= (state == ST_SAMPLE) && smp_expired;
    end

    // Result tag and end-of-chain pulses on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_ch    <= '0;
            res_flow  <= 2'd0;
            eoc_q     <= '0;
        end else begin
            res_valid <= done_seen;
            eoc_q     <= clr_v & last_v;
            if (done_seen) begin
                res_ch   <= act_ch;
                res_flow <= act_flow;
            end
        end
    end

    assign ch_sel     = act_ch;
    assign sample_en  = (state == ST_SAMPLE);
    assign conv_start = conv_start_q;
    assign eoc_reg    = eoc_q[FL_REG];
    assign eoc_hw     = eoc_q[FL_HW];
    assign eoc_sw     = eoc_q[FL_SW];
    assign busy       = (state != ST_IDLE) || (|pend_any);

endmodule

// File: rtl/adc_seq_checker.sv
// Module: adc_seq_checker
// Protocol and priority properties of the sequencer, bound into the top.
// Assumes pend_any order {sw, hw, reg} and the flow codes of the package.
module adc_seq_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_en,
    input logic          conv_start,
    input logic          conv_done,
    input logic          res_valid,
    input logic          eoc_reg,
    input logic          eoc_hw,
    input logic          eoc_sw,
    input logic          busy,
    input logic          sw_over_hw,
    input logic [CW-1:0] ch_sel,
    input logic [2:0]    pend_any,
    input logic [1:0]    act_flow
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !sample_en && !res_valid)); // R1
    AST_INJ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sample_en) && act_flow == 2'd0) |-> ($past(pend_any[2:1]) == 2'b00)); // R4
    AST_SW_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sample_en) && act_flow == 2'd1) |-> !($past(sw_over_hw) && $past(pend_any[2]))); // R5
    AST_HW_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sample_en) && act_flow == 2'd2) |-> !(!$past(sw_over_hw) && $past(pend_any[1]))); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sample_en && conv_start)); // R7
    AST_CONV_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(sample_en) |-> conv_start); // R7
    AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && $past(sample_en)) |-> $stable(ch_sel)); // R7
    AST_RESULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(conv_done)); // R8
    AST_EOC_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_reg || eoc_hw || eoc_sw) |-> res_valid); // R9
    AST_EOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({eoc_sw, eoc_hw, eoc_reg})); // R9

endmodule

bind adc_cmd_sequencer adc_seq_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .res_valid  (res_valid),
    .eoc_reg    (eoc_reg),
    .eoc_hw     (eoc_hw),
    .eoc_sw     (eoc_sw),
    .busy       (busy),
    .sw_over_hw (sw_over_hw),
    .ch_sel     (ch_sel),
    .pend_any   (pend_any),
    .act_flow   (act_flow)
);

// File: tb/adc_cmd_sequencer_test.sv
module adc_cmd_sequencer_test;

    localparam int NCH = 16;
    localparam int CWB = 4;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_start = 0, hw_start = 0, sw_start = 0;
    logic [NCH-1:0] reg_mask = '0, hw_mask = '0, sw_mask = '0;
    logic sw_over_hw = 0;
    logic [1:0] smp_sel = 2'd0;
    logic conv_done = 0;
    logic [CWB-1:0] ch_sel, res_ch;
    logic sample_en, conv_start, res_valid, eoc_reg, eoc_hw, eoc_sw, busy;
    logic [1:0] res_flow;

    int n_chk = 0, n_fail = 0;
    int exp_ch [256];
    int exp_fl [256];
    bit exp_last [256];
    int exp_n = 0, got_n = 0;
    int exp_len = 2;
    int run_len = 0;
    bit prev_smp = 0;
    int smp_ch = 0;
    bit done_flag = 0;

    adc_cmd_sequencer #(.NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n),
        .reg_start(reg_start), .reg_mask(reg_mask),
        .hw_start(hw_start), .hw_mask(hw_mask),
        .sw_start(sw_start), .sw_mask(sw_mask),
        .sw_over_hw(sw_over_hw), .smp_sel(smp_sel), .conv_done(conv_done),
        .ch_sel(ch_sel), .sample_en(sample_en), .conv_start(conv_start),
        .res_valid(res_valid), .res_ch(res_ch), .res_flow(res_flow),
        .eoc_reg(eoc_reg), .eoc_hw(eoc_hw), .eoc_sw(eoc_sw), .busy(busy)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'd0: return 2;
            2'd1: return 8;
            2'd2: return 64;
            default: return 128;
        endcase
    endfunction

    // Append a flow's channels in ascending order; mark the final one if asked.
    task automatic push_mask(input int fl, input logic [NCH-1:0] m, input bit mark_last);
        int last_i = -1;
        for (int i = 0; i < NCH; i++) if (m[i]) last_i = i;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                exp_ch[exp_n] = i;
                exp_fl[exp_n] = fl;
                exp_last[exp_n] = mark_last && (i == last_i);
                exp_n++;
            end
        end
    endtask

    // Converter model: conv_done LAT cycles after conv_start.
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                repeat (LAT - 1) @(negedge clk);
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // Output monitor: results, eoc, sample length, convert start, channel hold.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample_en && !prev_smp) smp_ch = ch_sel;
            if (sample_en) begin
                run_len++;
                chk(ch_sel == smp_ch, "R7 ch_sel held", ch_sel, smp_ch);
            end
            if (prev_smp && !sample_en) begin
                chk(run_len == exp_len, "R6 sample length", run_len, exp_len);
                chk(conv_start == 1'b1, "R7 conv_start after sample", conv_start, 1);
                run_len = 0;
            end
            if (res_valid) begin
                if (got_n < exp_n) begin
                    chk(res_ch == exp_ch[got_n], "R3 R4 R5 result channel", res_ch, exp_ch[got_n]);
                    chk(res_flow == exp_fl[got_n], "R3 R4 R5 result flow", res_flow, exp_fl[got_n]);
                    chk({eoc_sw, eoc_hw, eoc_reg} == (exp_last[got_n] ? (3'b001 << exp_fl[got_n]) : 3'b000),
                        "R9 end of chain", {eoc_sw, eoc_hw, eoc_reg},
                        exp_last[got_n] ? (1 << exp_fl[got_n]) : 0);
                    chk(res_ch == smp_ch, "R7 result matches sampled ch", res_ch, smp_ch);
                end else begin
                    chk(1'b0, "R2 unexpected result", res_ch, -1);
                end
                got_n++;
            end
            prev_smp = sample_en;
        end
    end

    task automatic wait_idle;
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_starts(input bit r, input bit h, input bit s);
        reg_start = r; hw_start = h; sw_start = s;
        @(negedge clk);
        reg_start = 0; hw_start = 0; sw_start = 0;
    endtask

    // Load all three flows at once from idle and check the full order.
    task automatic run_batch(input logic [NCH-1:0] rm, input logic [NCH-1:0] hm,
                             input logic [NCH-1:0] sm, input bit sov, input logic [1:0] code);
        exp_n = 0; got_n = 0;
        sw_over_hw = sov; smp_sel = code; exp_len = len_of(code);
        if (sov) begin push_mask(2, sm, 1); push_mask(1, hm, 1); end
        else     begin push_mask(1, hm, 1); push_mask(2, sm, 1); end
        push_mask(0, rm, 1);
        reg_mask = rm; hw_mask = hm; sw_mask = sm;
        @(negedge clk);
        pulse_starts(1, 1, 1);
        wait_idle();
        chk(got_n == exp_n, "R3 result count", got_n, exp_n);
        chk(busy == 1'b0, "R10 idle after batch", busy, 0);
    endtask

    initial begin
        logic [NCH-1:0] m, h, first2, rest;
        int lo;
        void'($urandom(32'h5EED_0A0C));
        repeat (3) @(negedge clk);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(sample_en == 0 && conv_start == 0, "R1 reset strobes", sample_en, 0);
        chk(res_valid == 0 && {eoc_sw, eoc_hw, eoc_reg} == 0, "R1 reset result", res_valid, 0);
        chk(ch_sel == 0, "R1 reset ch_sel", ch_sel, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && sample_en == 0, "R1 after release", busy, 0);

        // R2: zero masks are ignored.
        exp_n = 0; got_n = 0;
        reg_mask = '0; hw_mask = '0; sw_mask = '0;
        pulse_starts(1, 1, 1);
        repeat (4) @(negedge clk);
        chk(busy == 0, "R2 zero mask ignored", busy, 0);

        // R10: busy rises while work is outstanding.
        exp_n = 0; got_n = 0; exp_len = 2; smp_sel = 0;
        push_mask(0, 16'h8001, 1);
        reg_mask = 16'h8001;
        pulse_starts(1, 0, 0);
        chk(busy == 1, "R10 busy during scan", busy, 1);
        wait_idle();
        chk(got_n == 2, "R3 top and bottom channels", got_n, 2);

        // R6: the long sample codes on single channels.
        run_batch(16'h0000, 16'h0000, 16'h0020, 1'b0, 2'd2);
        run_batch(16'h0400, 16'h0000, 16'h0000, 1'b1, 2'd3);

        // R2: start while the flow is outstanding is ignored.
        exp_n = 0; got_n = 0; smp_sel = 0; exp_len = 2;
        push_mask(0, 16'h0003, 1);
        reg_mask = 16'h0003;
        pulse_starts(1, 0, 0);
        @(negedge clk);
        reg_mask = 16'hFFFF;
        pulse_starts(1, 0, 0);
        wait_idle();
        chk(got_n == 2, "R2 start while outstanding ignored", got_n, 2);

        // R8: stray conv_done during sampling has no effect.
        exp_n = 0; got_n = 0; smp_sel = 1; exp_len = 8;
        push_mask(1, 16'h0010, 1);
        hw_mask = 16'h0010;
        pulse_starts(0, 1, 0);
        while (!sample_en) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        chk(res_valid == 0 && sample_en == 1, "R8 stray conv_done ignored", res_valid, 0);
        wait_idle();
        chk(got_n == 1, "R8 single result", got_n, 1);

        // R4: injection in the middle of a regular scan; the scan resumes.
        for (int t = 0; t < 4; t++) begin
            exp_n = 0; got_n = 0; smp_sel = 2'(t & 1); exp_len = len_of(smp_sel);
            sw_over_hw = t[1];
            m = ($urandom() & 16'hFFF0) | 16'h0007;
            h = NCH'($urandom()) | 16'h0100;
            lo = 0;
            first2 = '0;
            for (int i = 0; i < NCH; i++) if (m[i] && lo < 2) begin first2[i] = 1'b1; lo++; end
            rest = m & ~first2;
            push_mask(0, first2, 0);
            push_mask(t[0] ? 2 : 1, h, 1);
            push_mask(0, rest, 1);
            reg_mask = m; hw_mask = h; sw_mask = h;
            pulse_starts(1, 0, 0);
            while (got_n < 1) @(negedge clk);
            while (!sample_en) @(negedge clk);
            pulse_starts(0, !t[0], t[0]);
            wait_idle();
            chk(got_n == exp_n, "R4 resume count", got_n, exp_n);
        end

        // R5 and R3: random batches with both priorities.
        for (int b = 0; b < 40; b++) begin
            run_batch(NCH'($urandom()), NCH'($urandom()) & NCH'($urandom()),
                      NCH'($urandom()) & NCH'($urandom()), 1'($urandom()), 2'($urandom() & 1));
        end

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule